// File: doc/BRIEF.md
# Multilevel Memory Charge Drift Test Sequencer

This block runs a charge-retention characterisation pass over a rectangle of cells in a multilevel dynamic memory whose cells hold thermometer-coded levels. After a start pulse it fills every selected cell with the top level (all code bits set), then leaves the array untouched for a programmable number of clock cycles, and then reads the rectangle back one row page at a time.

For every cell read back it emits one bitmap record on a valid/ready stream: row, column, the raw code read, how many levels the code has fallen below the top level, and a flag for a code that is not a legal thermometer pattern. A downstream collector builds the drift map from these records. When the final record has been taken and the final page closed, a done flag rises and stays up until the next start.

Top module: `drift_test_seq`

## Requirements
- R1: After reset `busy`, `done` and `bm_valid` are 0 and `mem_cmd` is NOP (0). A `start` pulse while idle or done, with non-zero row and column counts, raises `busy` and clears `done` in the next cycle; `start` while busy is ignored.
- R2: Fill phase: for each row, starting at `cfg_base_row` and rising by one (modulo the row width), the block issues OPEN (1) once, then WRITE (2) with `mem_wdata` = 5'b11111 for columns 0 up to `cfg_cols`-1 in rising order, then CLOSE (4).
- R3: Between acceptance of the final fill CLOSE and the first readback OPEN, exactly `cfg_drift_cycles` cycles pass with `mem_cmd` = NOP when `mem_rdy` stays high; a value of 0 presents the OPEN in the very next cycle.
- R4: Readback is page mode: per row in the same rising order, one OPEN, READ (3) for columns in rising order, one CLOSE; READ or WRITE only occurs while a page is open, and OPEN only while none is.
- R5: Each record carries `bm_row`, `bm_col`, the code `bm_code` returned for that cell, and `bm_drift` = 5 minus the number of ones in `bm_code` (3 bits).
- R6: Codes fill from bit 0 upward; `bm_invalid` is 1 exactly when some bit i+1 is 1 while bit i is 0.
- R7: While `bm_valid` is high and `bm_ready` low, every record field stays stable, and no further READ is issued until the record is taken.
- R8: `done` rises after the last record of the last row is taken and its page closed; it then stays high, with no memory commands, until the next `start`.
- R9: A command whose `mem_rdy` is low is held with the same row and column until accepted.
- R10: A `start` with a zero row count or zero column count issues no memory command and leaves the block done and not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, samples the configuration |
| cfg_base_row | input | ROW_W | First row of the range |
| cfg_rows | input | ROW_W | Number of rows |
| cfg_cols | input | COL_W | Columns per page |
| cfg_drift_cycles | input | 32 | Idle interval in clock cycles |
| busy | output | 1 | Test in progress |
| done | output | 1 | Test complete, held until next start |
| mem_cmd | output | 3 | 0 NOP, 1 OPEN, 2 WRITE, 3 READ, 4 CLOSE |
| mem_row | output | ROW_W | Row for the command |
| mem_col | output | COL_W | Column for the command |
| mem_wdata | output | 5 | Write code |
| mem_rdy | input | 1 | Command accepted this cycle |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 5 | Read code |
| bm_valid | output | 1 | Bitmap record valid |
| bm_ready | input | 1 | Bitmap record taken |
| bm_row | output | ROW_W | Record row |
| bm_col | output | COL_W | Record column |
| bm_code | output | 5 | Raw code read |
| bm_drift | output | 3 | Levels lost from the top |
| bm_invalid | output | 1 | Illegal thermometer code |

## Verification
The end of the fill phase and the start of readback can land on the same clock edge: with a zero drift interval the final fill CLOSE is accepted and the first readback OPEN must appear in the following cycle, with no idle cycle between and no stale page state. The bench provokes this with a zero interval and with short and long non-zero intervals, logs the cycle of every accepted command, and judges the count of idle cycles between those two commands against the configured value. A second collision, a memory stall coinciding with a stalled bitmap stream, is provoked with pseudo-random stall patterns on both and judged by hold checks on every stalled cycle.

// File: rtl/drift_pkg.sv
package drift_pkg;

    localparam int CODE_W = 5;
    localparam int MAG_W  = 3;
    localparam logic [CODE_W-1:0] CODE_TOP = '1;

    typedef enum logic [2:0] {
        MC_NOP   = 3'd0,
        MC_OPEN  = 3'd1,
        MC_WRITE = 3'd2,
        MC_READ  = 3'd3,
        MC_CLOSE = 3'd4
    } mem_cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_WOPEN, ST_WCOL, ST_WCLOSE, ST_WAIT,
        ST_ROPEN, ST_RCOL, ST_RDATA, ST_REMIT, ST_RCLOSE, ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [MAG_W-1:0]  mag;
        logic              bad;
    } cell_verdict_t;

    function automatic logic [MAG_W-1:0] ones_in(input logic [CODE_W-1:0] c);
        logic [MAG_W-1:0] n;
        n = '0;
        for (int i = 0; i < CODE_W; i++) begin
            n = n + MAG_W'(c[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/drift_code_classify.sv
module drift_code_classify
    import drift_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output cell_verdict_t     verdict_o
);

    logic [CODE_W-2:0] hole;

    genvar gi;
    generate
        for (gi = 0; gi < CODE_W - 1; gi++) begin : g_hole
            assign hole[gi] = code_i[gi+1] & ~code_i[gi];
        end
    endgenerate

    always_comb begin
        verdict_o.code = code_i;
        verdict_o.mag  = MAG_W'(CODE_W) - ones_in(code_i);
        verdict_o.bad  = |hole;
    end

endmodule

// File: rtl/drift_addr_walk.sv
module drift_addr_walk #(
    parameter int ROW_W = 8,
    parameter int COL_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             rewind,
    input  logic             step_col,
    input  logic             step_row,
    input  logic [ROW_W-1:0] base_i,
    input  logic [ROW_W-1:0] rows_i,
    input  logic [COL_W-1:0] cols_i,
    output logic [ROW_W-1:0] row_o,
    output logic [COL_W-1:0] col_o,
    output logic             last_col_o,
    output logic             last_row_o
);

    logic [ROW_W-1:0] base_q, rows_q, idx_q;
    logic [COL_W-1:0] cols_q, col_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            rows_q <= '0;
            cols_q <= '0;
            idx_q  <= '0;
            col_q  <= '0;
        end else if (load) begin
            base_q <= base_i;
            rows_q <= rows_i;
            cols_q <= cols_i;
            idx_q  <= '0;
            col_q  <= '0;
        end else if (rewind) begin
            idx_q <= '0;
            col_q <= '0;
        end else if (step_row) begin
            idx_q <= idx_q + ROW_W'(1);
            col_q <= '0;
        end else if (step_col) begin
            col_q <= col_q + COL_W'(1);
        end
    end

    assign row_o      = base_q + idx_q;
    assign col_o      = col_q;
    assign last_col_o = (col_q == cols_q - COL_W'(1));
    assign last_row_o = (idx_q == rows_q - ROW_W'(1));

    AST_COL_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (cols_q != '0) |-> (col_q < cols_q));                            // R4
    AST_ROW_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (rows_q != '0) |-> (idx_q < rows_q));                            // R4

endmodule

// File: rtl/drift_wait_timer.sv
module drift_wait_timer #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic [CNT_W-1:0] len_i,
    output logic             last_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (arm) begin
            cnt_q <= len_i - CNT_W'(1);
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) run_q <= 1'b0;
            else             cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign last_o = run_q && (cnt_q == '0);

    AST_ARM_NONZERO: assert property (@(posedge clk) disable iff (rst)
        arm |-> (len_i != '0));                                          // R3
    AST_ARM_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        arm |-> !run_q);                                                 // R3
    AST_TIMER_STOPS: assert property (@(posedge clk) disable iff (rst)
        last_o |=> !run_q);                                              // R3

endmodule

// File: rtl/drift_test_seq.sv
module drift_test_seq
    import drift_pkg::*;
#(
    parameter int ROW_W = 8,
    parameter int COL_W = 6,
    parameter int TMR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ROW_W-1:0]  cfg_base_row,
    input  logic [ROW_W-1:0]  cfg_rows,
    input  logic [COL_W-1:0]  cfg_cols,
    input  logic [TMR_W-1:0]  cfg_drift_cycles,
    output logic              busy,
    output logic              done,
    output logic [2:0]        mem_cmd,
    output logic [ROW_W-1:0]  mem_row,
    output logic [COL_W-1:0]  mem_col,
    output logic [CODE_W-1:0] mem_wdata,
    input  logic              mem_rdy,
    input  logic              mem_rvalid,
    input  logic [CODE_W-1:0] mem_rdata,
    output logic              bm_valid,
    input  logic              bm_ready,
    output logic [ROW_W-1:0]  bm_row,
    output logic [COL_W-1:0]  bm_col,
    output logic [CODE_W-1:0] bm_code,
    output logic [MAG_W-1:0]  bm_drift,
    output logic              bm_invalid
);

    seq_state_e        state_q, state_d;
    logic [TMR_W-1:0]  drift_q;
    logic [CODE_W-1:0] code_q;
    logic              page_open_q;
    logic              load, rewind, step_col, step_row, arm, capture;
    logic [ROW_W-1:0]  walk_row;
    logic [COL_W-1:0]  walk_col;
    logic              last_col, last_row, tmr_last;
    mem_cmd_e          cmd;
    cell_verdict_t     verdict;

    drift_addr_walk #(.ROW_W(ROW_W), .COL_W(COL_W)) u_walk (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .rewind     (rewind),
        .step_col   (step_col),
        .step_row   (step_row),
        .base_i     (cfg_base_row),
        .rows_i     (cfg_rows),
        .cols_i     (cfg_cols),
        .row_o      (walk_row),
        .col_o      (walk_col),
        .last_col_o (last_col),
        .last_row_o (last_row)
    );

    drift_wait_timer #(.CNT_W(TMR_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .arm    (arm),
        .len_i  (drift_q),
        .last_o (tmr_last)
    );

    drift_code_classify u_class (
        .code_i    (code_q),
        .verdict_o (verdict)
    );

    // Command decode from the sequencer state
    always_comb begin
        unique case (state_q)
            ST_WOPEN, ST_ROPEN:   cmd = MC_OPEN;
            ST_WCOL:              cmd = MC_WRITE;
            ST_RCOL:              cmd = MC_READ;
            ST_WCLOSE, ST_RCLOSE: cmd = MC_CLOSE;
            default:              cmd = MC_NOP;
        endcase
    end

    // Next state and walker/timer control
    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        rewind   = 1'b0;
        step_col = 1'b0;
        step_row = 1'b0;
        arm      = 1'b0;
        capture  = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    load    = 1'b1;
                    state_d = (cfg_rows == '0 || cfg_cols == '0) ? ST_DONE : ST_WOPEN;
                end
            end
            ST_WOPEN: if (mem_rdy) state_d = ST_WCOL;
            ST_WCOL: begin
                if (mem_rdy) begin
                    if (last_col) state_d = ST_WCLOSE;
                    else          step_col = 1'b1;
                end
            end
            ST_WCLOSE: begin
                if (mem_rdy) begin
                    if (last_row) begin
                        rewind = 1'b1;
                        if (drift_q == '0) begin
                            state_d = ST_ROPEN;
                        end else begin
                            arm     = 1'b1;
                            state_d = ST_WAIT;
                        end
                    end else begin
                        step_row = 1'b1;
                        state_d  = ST_WOPEN;
                    end
                end
            end
            ST_WAIT:  if (tmr_last) state_d = ST_ROPEN;
            ST_ROPEN: if (mem_rdy) state_d = ST_RCOL;
            ST_RCOL:  if (mem_rdy) state_d = ST_RDATA;
            ST_RDATA: begin
                if (mem_rvalid) begin
                    capture = 1'b1;
                    state_d = ST_REMIT;
                end
            end
            ST_REMIT: begin
                if (bm_ready) begin
                    if (last_col) begin
                        state_d = ST_RCLOSE;
                    end else begin
                        step_col = 1'b1;
                        state_d  = ST_RCOL;
                    end
                end
            end
            ST_RCLOSE: begin
                if (mem_rdy) begin
                    if (last_row) begin
                        state_d = ST_DONE;
                    end else begin
                        step_row = 1'b1;
                        state_d  = ST_ROPEN;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            drift_q     <= '0;
            code_q      <= '0;
            page_open_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load)    drift_q <= cfg_drift_cycles;
            if (capture) code_q  <= mem_rdata;
            if (mem_rdy && cmd == MC_OPEN)  page_open_q <= 1'b1;
            if (mem_rdy && cmd == MC_CLOSE) page_open_q <= 1'b0;
        end
    end

    assign mem_cmd    = cmd;
    assign mem_row    = walk_row;
    assign mem_col    = walk_col;
    assign mem_wdata  = CODE_TOP;
    assign busy       = (state_q != ST_IDLE) && (state_q != ST_DONE);
    assign done       = (state_q == ST_DONE);
    assign bm_valid   = (state_q == ST_REMIT);
    assign bm_row     = walk_row;
    assign bm_col     = walk_col;
    assign bm_code    = verdict.code;
    assign bm_drift   = verdict.mag;
    assign bm_invalid = verdict.bad;

    AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT) |-> (mem_cmd == MC_NOP));                   // R3
    AST_ACCESS_IN_PAGE: assert property (@(posedge clk) disable iff (rst)
        (mem_cmd == MC_WRITE || mem_cmd == MC_READ) |-> page_open_q);    // R4
    AST_OPEN_ON_CLOSED: assert property (@(posedge clk) disable iff (rst)
        (mem_cmd == MC_OPEN) |-> !page_open_q);                          // R4
    AST_TOP_CODE_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (bm_valid && bm_code == CODE_TOP) |-> (bm_drift == '0 && !bm_invalid)); // R5
    AST_EMPTY_CODE_FULL_DRIFT: assert property (@(posedge clk) disable iff (rst)
        (bm_valid && bm_code == '0) |-> (bm_drift == MAG_W'(CODE_W) && !bm_invalid)); // R5
    AST_RECORD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (bm_valid && !bm_ready) |=> (bm_valid && $stable(bm_row) && $stable(bm_col)
                                     && $stable(bm_code) && $stable(bm_invalid))); // R7
    AST_NO_READ_WHILE_PENDING: assert property (@(posedge clk) disable iff (rst)
        bm_valid |-> (mem_cmd == MC_NOP));                               // R7
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        done |-> (mem_cmd == MC_NOP && !bm_valid && !busy));             // R8
    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_cmd != MC_NOP && !mem_rdy) |=> (mem_cmd == $past(mem_cmd)
                                             && $stable(mem_row) && $stable(mem_col))); // R9

endmodule

// File: tb/test_drift_test_seq.sv
module test_drift_test_seq;

    localparam int ROW_W = 4;
    localparam int COL_W = 3;
    localparam int LOG_N = 256;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [ROW_W-1:0] cfg_base_row = '0;
    logic [ROW_W-1:0] cfg_rows = '0;
    logic [COL_W-1:0] cfg_cols = '0;
    logic [31:0]      cfg_drift_cycles = '0;
    logic             busy, done;
    logic [2:0]       mem_cmd;
    logic [ROW_W-1:0] mem_row;
    logic [COL_W-1:0] mem_col;
    logic [4:0]       mem_wdata;
    logic             mem_rdy = 1'b1;
    logic             mem_rvalid = 1'b0;
    logic [4:0]       mem_rdata = '0;
    logic             bm_valid;
    logic             bm_ready = 1'b1;
    logic [ROW_W-1:0] bm_row;
    logic [COL_W-1:0] bm_col;
    logic [4:0]       bm_code;
    logic [2:0]       bm_drift;
    logic             bm_invalid;

    drift_test_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .TMR_W(32)) i_drift_test_seq (
        .clk(clk), .rst(rst), .start(start), .cfg_base_row(cfg_base_row),
        .cfg_rows(cfg_rows), .cfg_cols(cfg_cols), .cfg_drift_cycles(cfg_drift_cycles),
        .busy(busy), .done(done), .mem_cmd(mem_cmd), .mem_row(mem_row),
        .mem_col(mem_col), .mem_wdata(mem_wdata), .mem_rdy(mem_rdy),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .bm_valid(bm_valid),
        .bm_ready(bm_ready), .bm_row(bm_row), .bm_col(bm_col), .bm_code(bm_code),
        .bm_drift(bm_drift), .bm_invalid(bm_invalid)
    );

    always #2 clk = ~clk;  // 250 MHz

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    // Memory model and logs
    logic [4:0] arr [0:15][0:7];
    int lg_cmd [0:LOG_N-1];
    int lg_row [0:LOG_N-1];
    int lg_col [0:LOG_N-1];
    int lg_wd  [0:LOG_N-1];
    int lg_cyc [0:LOG_N-1];
    int lg_n = 0;
    int en_row [0:LOG_N-1];
    int en_col [0:LOG_N-1];
    int en_code[0:LOG_N-1];
    int en_mag [0:LOG_N-1];
    int en_bad [0:LOG_N-1];
    int en_n = 0;
    int salt = 0;
    bit stall = 0;
    logic [7:0] lfsr = 8'h5A;
    bit pend_rd = 0;
    logic [4:0] pend_data = '0;
    int hold_bad = 0;
    int stall_seen = 0;
    bit p_cmd_stall = 0, p_bm_stall = 0;
    logic [2:0] p_cmd;
    logic [ROW_W-1:0] p_row, p_brow;
    logic [COL_W-1:0] p_col, p_bcol;
    logic [4:0] p_code;
    logic [2:0] p_mag;
    logic p_bad;

    function automatic int mask_of(input int r, input int c);
        int k;
        k = (r * 3 + c + salt) % 7;
        case (k)
            0: return 31;
            1: return 15;
            2: return 7;
            3: return 3;
            4: return 0;
            5: return 27;
            default: return 1;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc++;

    // Monitor: sample away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (p_cmd_stall && (mem_cmd != p_cmd || mem_row != p_row || mem_col != p_col))
                hold_bad++;
            if (p_bm_stall && (!bm_valid || bm_row != p_brow || bm_col != p_bcol ||
                               bm_code != p_code || bm_drift != p_mag || bm_invalid != p_bad))
                hold_bad++;
            if (p_bm_stall && mem_cmd == 3'd3) hold_bad++;
            if ((mem_cmd != 3'd0 && !mem_rdy) || (bm_valid && !bm_ready)) stall_seen++;
            if (mem_cmd != 3'd0 && mem_rdy && lg_n < LOG_N) begin
                lg_cmd[lg_n] = int'(mem_cmd);
                lg_row[lg_n] = int'(mem_row);
                lg_col[lg_n] = int'(mem_col);
                lg_wd[lg_n]  = int'(mem_wdata);
                lg_cyc[lg_n] = cyc;
                lg_n++;
                if (mem_cmd == 3'd2) arr[mem_row][mem_col] = mem_wdata;
                if (mem_cmd == 3'd3) begin
                    pend_rd   = 1;
                    pend_data = arr[mem_row][mem_col] & 5'(mask_of(int'(mem_row), int'(mem_col)));
                end
            end
            if (bm_valid && bm_ready && en_n < LOG_N) begin
                en_row[en_n]  = int'(bm_row);
                en_col[en_n]  = int'(bm_col);
                en_code[en_n] = int'(bm_code);
                en_mag[en_n]  = int'(bm_drift);
                en_bad[en_n]  = int'(bm_invalid);
                en_n++;
            end
            p_cmd_stall = (mem_cmd != 3'd0) && !mem_rdy;
            p_bm_stall  = bm_valid && !bm_ready;
            p_cmd = mem_cmd; p_row = mem_row; p_col = mem_col;
            p_brow = bm_row; p_bcol = bm_col; p_code = bm_code;
            p_mag = bm_drift; p_bad = bm_invalid;
        end
    end

    // Stimulus for memory responses and stalls, driven just after the edge
    always @(posedge clk) begin
        #1;
        mem_rvalid = pend_rd;
        mem_rdata  = pend_rd ? pend_data : 5'd0;
        pend_rd    = 0;
        if (stall) begin
            lfsr     = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            mem_rdy  = lfsr[0] | lfsr[3];
            bm_ready = lfsr[1] & lfsr[6] | lfsr[2];
        end else begin
            mem_rdy  = 1'b1;
            bm_ready = 1'b1;
        end
    end

    task automatic clear_logs();
        lg_n = 0; en_n = 0; hold_bad = 0; stall_seen = 0;
        for (int r = 0; r < 16; r++)
            for (int c = 0; c < 8; c++) arr[r][c] = 5'd0;
    endtask

    task automatic pulse_start(input int base, input int rows, input int cols, input int dly);
        @(posedge clk); #1;
        cfg_base_row = ROW_W'(base); cfg_rows = ROW_W'(rows);
        cfg_cols = COL_W'(cols); cfg_drift_cycles = dly;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    // One full characterisation pass with its own checks
    task automatic run_pass(input int base, input int rows, input int cols,
                            input int dly, input bit stl, input int slt);
        int k, nw, bad, first_bad_act, first_bad_exp, gap, ones, eb, row;
        bit seen;
        clear_logs();
        salt = slt;
        stall = stl;
        pulse_start(base, rows, cols, dly);
        @(negedge clk);
        chk(busy && !done, "R1 busy after start", int'(busy), 1);
        seen = 0;
        for (int i = 0; i < 20000; i++) begin
            if (done) begin seen = 1; break; end
            @(negedge clk);
        end
        chk(seen, "R8 done reached", int'(seen), 1);
        stall = 0;
        nw = rows * (cols + 2);
        chk(lg_n == 2 * nw, "R2 R4 command count", lg_n, 2 * nw);
        // Expected command stream: fill then readback, page per row
        bad = 0; first_bad_act = 0; first_bad_exp = 0;
        k = 0;
        for (int ph = 0; ph < 2; ph++) begin
            for (int r = 0; r < rows; r++) begin
                row = (base + r) % 16;
                if (k < lg_n && (lg_cmd[k] != 1 || lg_row[k] != row)) begin
                    if (bad == 0) begin first_bad_act = lg_cmd[k]; first_bad_exp = 1; end
                    bad++;
                end
                k++;
                for (int c = 0; c < cols; c++) begin
                    if (k < lg_n && (lg_cmd[k] != (ph == 0 ? 2 : 3) || lg_row[k] != row ||
                        lg_col[k] != c || (ph == 0 && lg_wd[k] != 31))) begin
                        if (bad == 0) begin first_bad_act = lg_col[k]; first_bad_exp = c; end
                        bad++;
                    end
                    k++;
                end
                if (k < lg_n && lg_cmd[k] != 4) begin
                    if (bad == 0) begin first_bad_act = lg_cmd[k]; first_bad_exp = 4; end
                    bad++;
                end
                k++;
            end
        end
        chk(bad == 0, "R2 R4 command order and fill data", first_bad_act, first_bad_exp);
        if (!stl && lg_n == 2 * nw) begin
            gap = lg_cyc[nw] - lg_cyc[nw - 1] - 1;
            chk(gap == dly, "R3 idle gap before readback", gap, dly);
        end
        // Expected bitmap records
        chk(en_n == rows * cols, "R5 record count", en_n, rows * cols);
        bad = 0; first_bad_act = 0; first_bad_exp = 0;
        k = 0;
        for (int r = 0; r < rows; r++) begin
            for (int c = 0; c < cols; c++) begin
                int code;
                row = (base + r) % 16;
                code = 31 & mask_of(row, c);
                ones = 0;
                for (int b = 0; b < 5; b++) ones += (code >> b) & 1;
                eb = 0;
                for (int b = 0; b < 4; b++)
                    if (((code >> (b + 1)) & 1) == 1 && ((code >> b) & 1) == 0) eb = 1;
                if (k < en_n) begin
                    if (en_row[k] != row || en_col[k] != c || en_code[k] != code) begin
                        if (bad == 0) begin first_bad_act = en_code[k]; first_bad_exp = code; end
                        bad++;
                    end
                    if (en_mag[k] != 5 - ones) begin
                        chk(0, "R5 drift magnitude", en_mag[k], 5 - ones);
                    end
                    if (en_bad[k] != eb) begin
                        chk(0, "R6 invalid flag", en_bad[k], eb);
                    end
                end
                k++;
            end
        end
        chk(bad == 0, "R5 record address and code", first_bad_act, first_bad_exp);
        chk(hold_bad == 0, "R7 R9 hold under stall", hold_bad, 0);
        if (stl) chk(stall_seen > 0, "R7 R9 stalls provoked", stall_seen, 1);
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk(!busy && !done && !bm_valid && mem_cmd == 3'd0, "R1 reset state",
            int'({busy, done, bm_valid, mem_cmd}), 0);
    endtask

    task automatic test_done_sticky();
        int n0;
        n0 = lg_n;
        repeat (20) @(negedge clk);
        chk(done && !busy, "R8 done held", int'(done), 1);
        chk(lg_n == n0, "R8 no commands after done", lg_n, n0);
    endtask

    task automatic test_busy_start_ignored();
        // second start while busy must not restart the pass
        clear_logs();
        salt = 2;
        pulse_start(2, 2, 2, 40);
        repeat (5) @(negedge clk);
        pulse_start(9, 1, 1, 0);
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (done) break;
        end
        chk(lg_n == 2 * 2 * 4 && lg_row[0] == 2, "R1 start ignored while busy", lg_n, 16);
    endtask

    task automatic test_empty(input int rows, input int cols);
        clear_logs();
        pulse_start(4, rows, cols, 7);
        repeat (12) @(negedge clk);
        chk(lg_n == 0, "R10 no commands for empty range", lg_n, 0);
        chk(done && !busy, "R10 done without busy", int'({done, busy}), 2);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        test_reset();
        run_pass(3, 2, 3, 10, 0, 0);
        test_done_sticky();
        run_pass(0, 1, 7, 0, 0, 1);
        run_pass(5, 1, 2, 300, 0, 4);
        run_pass(14, 3, 4, 5, 1, 3);
        test_busy_start_ignored();
        test_empty(0, 3);
        test_empty(2, 0);
        run_pass(7, 2, 1, 1, 1, 5);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule